// File: doc/BRIEF.md
# Backup Supply Break-Before-Make Switchover Controller

This controller chooses where the memory backup regulator draws its power: the auxiliary system rail or the backup cell. Two comparator flags come in, one saying the aux rail is above its trip point and one saying the scaled cell voltage is above the low-cell threshold. Both are synchronised and debounced before they can act. A die over-temperature flag, a bias-ready flag and an active-low regulator enable also come in. The block drives the gates of the two mux switches, a run signal for the regulator and a dormant indicator.

The controller never closes both switches at once. A change of source in either direction opens the active switch first. Both switches then stay open for a fixed dead interval of `DEAD_CYC` clock cycles, with the regulator running from its hold-up capacitor, and only then does the other switch close. If the cell drops below the low threshold, the controller enters a latched dormant state. It leaves that state only when the aux rail is good again and bias is ready. A recovering cell does not release it.

States: `ST_DORMANT` (both open, reset state), `ST_AUX` (aux switch closed), `ST_GAP_TO_BAT` (both open, counting the dead interval), `ST_BAT` (cell switch closed) and `ST_GAP_TO_AUX` (both open, counting the dead interval). Transitions:
- DORMANT→AUX when aux is good and bias is ready.
- AUX→GAP_TO_BAT when aux is lost.
- GAP_TO_BAT→BAT at the end of the interval if the cell is good, or GAP_TO_BAT→DORMANT if it is low.
- BAT→DORMANT when the cell is low. This takes priority over the next transition.
- BAT→GAP_TO_AUX when aux returns.
- GAP_TO_AUX→AUX at the end of the interval.

Top module: `bkup_supply_switch`

## Requirements
- R1: While reset is asserted, and right after it, `dormant_o`=1, `aux_sw_o`=0, `bat_sw_o`=0 and `reg_run_o`=0.
- R2: `aux_sw_o` and `bat_sw_o` are never 1 in the same cycle.
- R3: When the debounced aux flag falls while the aux switch is closed, `aux_sw_o` goes to 0. Both switches then stay 0 for exactly `DEAD_CYC` cycles, after which `bat_sw_o` goes to 1 (the cell being good).
- R4: When the debounced aux flag rises while the cell switch is closed, `bat_sw_o` goes to 0. Both switches then stay 0 for exactly `DEAD_CYC` cycles, after which `aux_sw_o` goes to 1.
- R5: `reg_run_o` is 1 only when `reg_en_n_i`=0, `die_hot_i`=0 and the block is not dormant. With `reg_en_n_i`=1 the regulator is off even when the cell is selected.
- R6: When the debounced cell flag falls while the cell switch is closed, the block goes dormant: both switches are 0, `reg_run_o`=0 and `dormant_o`=1.
- R7: Dormant is left only when the debounced aux flag is 1 and `bias_ok_i`=1. The block then closes the aux switch directly. Cell recovery alone, or aux with `bias_ok_i`=0, keeps it dormant.
- R8: `die_hot_i`=1 forces `reg_run_o` to 0 and does not change which switch is closed.
- R9: A raw flag level that holds for fewer than `DEB_CYC` synchronised cycles has no effect.
- R10: If the debounced cell flag is low when the aux-to-cell dead interval ends, the block goes dormant without ever closing the cell switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_good_i | input | 1 | Raw comparator flag: aux rail above trip (asynchronous) |
| bat_good_i | input | 1 | Raw comparator flag: scaled cell above low threshold (asynchronous) |
| die_hot_i | input | 1 | Die over-temperature flag |
| bias_ok_i | input | 1 | Bias stable and regulator undervoltage lockout cleared |
| reg_en_n_i | input | 1 | Active-low regulator enable |
| aux_sw_o | output | 1 | Gate of the aux-rail mux switch |
| bat_sw_o | output | 1 | Gate of the cell mux switch |
| reg_run_o | output | 1 | Regulator run |
| dormant_o | output | 1 | Low-current dormant indicator |

## Verification
Four properties are checked in every cycle: the two gates are never both closed; no switch closes in the cycle right after the other one was closed; the dead-interval counter stays below its limit; and, whenever dormant, over-temperature or disable is active, the run signal is low and the gates are in their required states. Other behaviours depend on sequences of events and are shown only by the bench scenarios. These are: the exact length of the dead interval, the rejection of short glitches, the latching of the dormant state while the cell recovers or bias is missing, and the path from a low cell at the end of the interval straight to dormant.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;
    typedef enum logic [2:0] {
        ST_DORMANT    = 3'd0,
        ST_AUX        = 3'd1,
        ST_GAP_TO_BAT = 3'd2,
        ST_BAT        = 3'd3,
        ST_GAP_TO_AUX = 3'd4
    } bss_state_e;
endpackage

// File: rtl/bss_debounce.sv
`timescale 1ns/1ps
module bss_debounce #(
    parameter int   SYNC_STAGES = 2,
    parameter int   DEB_CYC     = 4,
    parameter logic RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   samp;

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // A new level is accepted only after DEB_CYC consecutive differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= RST_VAL;
            cnt_q <= '0;
        end else if (samp == dout) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYC - 1)) begin
            dout  <= samp;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_deb_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(DEB_CYC));
endmodule

// File: rtl/bss_fsm.sv
`timescale 1ns/1ps
module bss_fsm
    import bss_pkg::*;
#(
    parameter int DEAD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_ok,
    input  logic bat_ok,
    input  logic bias_ok,
    input  logic die_hot,
    input  logic reg_en_n,
    output logic aux_sw,
    output logic bat_sw,
    output logic reg_run,
    output logic dormant
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    bss_state_e state_q, state_d;
    logic [DW-1:0] gap_q;
    logic          gap_end;

    assign gap_end = (gap_q == DW'(DEAD_CYC - 1));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DORMANT:    if (aux_ok && bias_ok) state_d = ST_AUX;
            ST_AUX:        if (!aux_ok)           state_d = ST_GAP_TO_BAT;
            ST_GAP_TO_BAT: if (gap_end)           state_d = bat_ok ? ST_BAT : ST_DORMANT;
            ST_BAT: begin
                if (!bat_ok)     state_d = ST_DORMANT;
                else if (aux_ok) state_d = ST_GAP_TO_AUX;
            end
            ST_GAP_TO_AUX: if (gap_end)           state_d = ST_AUX;
            default:                              state_d = ST_DORMANT;
        endcase
    end

    // State register and dead-interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DORMANT;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) gap_q <= '0;
            else if (!gap_end)      gap_q <= gap_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        aux_sw  = 1'b0;
        bat_sw  = 1'b0;
        dormant = 1'b0;
        unique case (state_q)
            ST_DORMANT:    dormant = 1'b1;
            ST_AUX:        aux_sw  = 1'b1;
            ST_BAT:        bat_sw  = 1'b1;
            ST_GAP_TO_BAT,
            ST_GAP_TO_AUX: ;
            default:       dormant = 1'b1;
        endcase
        reg_run = !reg_en_n && !die_hot && (state_q != ST_DORMANT);
    end

    p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < DW'(DEAD_CYC));
endmodule

// File: rtl/bkup_supply_switch.sv
`timescale 1ns/1ps
module bkup_supply_switch #(
    parameter int DEAD_CYC    = 40,
    parameter int DEB_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_good_i,
    input  logic bat_good_i,
    input  logic die_hot_i,
    input  logic bias_ok_i,
    input  logic reg_en_n_i,
    output logic aux_sw_o,
    output logic bat_sw_o,
    output logic reg_run_o,
    output logic dormant_o
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] raw_flags, clean_flags;
    assign raw_flags = {bat_good_i, aux_good_i};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        bss_debounce #(
            .SYNC_STAGES (SYNC_STAGES),
            .DEB_CYC     (DEB_CYC),
            .RST_VAL     (1'b0)
        ) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_flags[g]),
            .dout  (clean_flags[g])
        );
    end

    bss_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_ok   (clean_flags[0]),
        .bat_ok   (clean_flags[1]),
        .bias_ok  (bias_ok_i),
        .die_hot  (die_hot_i),
        .reg_en_n (reg_en_n_i),
        .aux_sw   (aux_sw_o),
        .bat_sw   (bat_sw_o),
        .reg_run  (reg_run_o),
        .dormant  (dormant_o)
    );

    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_sw_o && bat_sw_o));
    p_bat_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_sw_o) |-> !$past(aux_sw_o));
    p_aux_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_sw_o) |-> !$past(bat_sw_o));
    p_disable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en_n_i |-> !reg_run_o);
    p_dormant_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dormant_o |-> (!reg_run_o && !aux_sw_o && !bat_sw_o));
    p_hot_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        die_hot_i |-> !reg_run_o);
endmodule

// File: tb/bkup_supply_switch_tb.sv
`timescale 1ns/1ps
module bkup_supply_switch_tb;
    localparam int DEAD_CYC = 40;
    localparam int DEB_CYC  = 4;

    logic clk = 1'b0;
    logic rst_n, aux_good, bat_good, die_hot, bias_ok, reg_en_n;
    logic aux_sw, bat_sw, reg_run, dormant;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    bkup_supply_switch #(.DEAD_CYC(DEAD_CYC), .DEB_CYC(DEB_CYC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .aux_good_i(aux_good), .bat_good_i(bat_good),
        .die_hot_i(die_hot), .bias_ok_i(bias_ok), .reg_en_n_i(reg_en_n),
        .aux_sw_o(aux_sw), .bat_sw_o(bat_sw), .reg_run_o(reg_run), .dormant_o(dormant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2 monitor, sampled away from the active edge
    always @(negedge clk) if (rst_n === 1'b1 && !done) chk("R2 both switches closed", int'(aux_sw && bat_sw), 0);

    // Waits for the outgoing switch to open, then counts cycles with both open
    task automatic gap(input string tag, input bit to_bat, input int exp);
        int n = 0, w = 0;
        while ((to_bat ? aux_sw : bat_sw) && w < 200) begin @(negedge clk); w++; end
        while (!aux_sw && !bat_sw && n < 200) begin @(negedge clk); n++; end
        chk({tag, " gap length"}, n, exp);
        chk({tag, " incoming switch"}, int'(to_bat ? bat_sw : aux_sw), 1);
    endtask

    task automatic t_reset();
        rst_n = 0; aux_good = 1; bat_good = 1; die_hot = 0; bias_ok = 1; reg_en_n = 0;
        cyc(3);
        chk("R1 dormant in reset", int'(dormant), 1);
        chk("R1 aux open in reset", int'(aux_sw), 0);
        chk("R1 bat open in reset", int'(bat_sw), 0);
        chk("R1 run low in reset", int'(reg_run), 0);
        rst_n = 1;
        cyc(1);
        chk("R1 dormant after reset", int'(dormant), 1);
        cyc(20);
        chk("R7 leave dormant to aux", int'(aux_sw), 1);
        chk("R5 run on aux", int'(reg_run), 1);
    endtask

    task automatic t_glitch();
        aux_good = 0; cyc(2); aux_good = 1;
        cyc(20);
        chk("R9 glitch keeps aux", int'(aux_sw), 1);
        chk("R9 glitch keeps bat open", int'(bat_sw), 0);
    endtask

    task automatic t_to_bat();
        aux_good = 0;
        gap("R3", 1'b1, DEAD_CYC);
    endtask

    task automatic t_regctl();
        reg_en_n = 1; cyc(1);
        chk("R5 disabled on battery", int'(reg_run), 0);
        chk("R5 bat stays closed", int'(bat_sw), 1);
        reg_en_n = 0; die_hot = 1; cyc(1);
        chk("R8 hot stops run", int'(reg_run), 0);
        chk("R8 hot keeps bat", int'(bat_sw), 1);
        chk("R8 hot keeps aux open", int'(aux_sw), 0);
        die_hot = 0; cyc(1);
        chk("R5 run restored", int'(reg_run), 1);
    endtask

    task automatic t_to_aux();
        aux_good = 1;
        gap("R4", 1'b0, DEAD_CYC);
    endtask

    task automatic t_lowbat();
        aux_good = 0; cyc(100);
        chk("R3 on battery", int'(bat_sw), 1);
        bat_good = 0; cyc(20);
        chk("R6 dormant", int'(dormant), 1);
        chk("R6 bat open", int'(bat_sw), 0);
        chk("R6 aux open", int'(aux_sw), 0);
        chk("R6 run low", int'(reg_run), 0);
    endtask

    task automatic t_hold();
        bat_good = 1; cyc(20);
        chk("R7 cell recovery keeps dormant", int'(dormant), 1);
        bias_ok = 0; aux_good = 1; cyc(20);
        chk("R7 no bias keeps dormant", int'(dormant), 1);
        chk("R7 no bias aux open", int'(aux_sw), 0);
        bias_ok = 1; cyc(2);
        chk("R7 bias ready closes aux", int'(aux_sw), 1);
        chk("R7 dormant cleared", int'(dormant), 0);
    endtask

    task automatic t_breaklow();
        int seen = 0, w = 0;
        aux_good = 0;
        while (aux_sw && w < 200) begin @(negedge clk); w++; end
        bat_good = 0;
        for (int i = 0; i < DEAD_CYC + 20; i++) begin
            @(negedge clk);
            if (bat_sw) seen++;
        end
        chk("R10 bat never closed", seen, 0);
        chk("R10 dormant after gap", int'(dormant), 1);
    endtask

    initial begin
        rst_n = 0;
        t_reset();
        t_glitch();
        t_to_bat();
        t_regctl();
        t_to_aux();
        t_lowbat();
        t_hold();
        t_breaklow();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule